// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches one timer pin and records the value of a free-running count when the pin makes a selected kind of transition. The pin is brought into the local clock domain by a synchronizer. The synchronized level is then compared with its value one cycle earlier. An edge counts only if the mode asks for it and the pin is configured as an input. The first such edge stores the count in the first capture slot and the second stores it in the second slot. After that the unit is full and ignores edges until it is rearmed.

A one-cycle capture event pulse tells the interrupt logic that the selected capture has happened. It can follow the first capture, or it can wait for the second, so software can measure a period or a pulse width from two stamps and take only one interrupt. Rearming has two causes: a write that clears the capture status, or a move of the mode out of the disabled setting. Counting and interrupt merging belong to neighbouring blocks.

Top module: `edge_capture_pair`

## Requirements
- R1: `cap_mode_i` selects the edges that qualify: 0 means none, 1 means low-to-high, 2 means high-to-low and 3 means either. An edge that is not in the selected set changes neither slot and raises no event.
- R2: Edges are taken only while `pin_is_input_i` is 1. While it is 0, both slots hold their value and no event is raised.
- R3: After a rearm, the first qualifying edge writes `count_i` into `cap_first_o`. The second qualifying edge writes `count_i` into `cap_second_o`.
- R4: Once both slots are filled, later edges leave both slots unchanged and raise no event until a rearm.
- R5: A one-cycle pulse on `cap_clr_i` returns the slot index to the first slot. The stored values are kept.
- R6: A change of `cap_mode_i` from 0 to any nonzero value rearms the unit. A change between two nonzero modes does not rearm it.
- R7: `cap_event_o` pulses for one cycle, in the same cycle as the new slot value appears. With `second_sel_i` at 0 it follows the first capture, and with it at 1 it follows the second capture.
- R8: While `rst_n` is low, both slots read zero, `cap_event_o` is low and the index points to the first slot.
- R9: A pin change that is first sampled at clock edge k is captured at edge k+SYNC_STAGES. The stored value is `count_i` as it was just before that edge.
- R10: If a rearm and a qualifying edge fall in the same cycle, the rearm wins. The edge is dropped and no slot is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_async_i | input | 1 | Raw timer pin level, not yet synchronized |
| count_i | input | CNT_W | Running count value to be stamped |
| cap_mode_i | input | 2 | Edge selection (0 none, 1 rise, 2 fall, 3 both) |
| second_sel_i | input | 1 | 0: event on first capture, 1: event on second capture |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| cap_clr_i | input | 1 | Capture status clear strobe, rearms the index |
| cap_first_o | output | CNT_W | First capture slot |
| cap_second_o | output | CNT_W | Second capture slot |
| cap_event_o | output | 1 | One-cycle capture event |

## Verification
A slot index that is stuck or skips a value shows at the ports on the next qualifying edge. Either the wrong slot changes, or a slot changes when the unit should be full. A wrong rearm shows within two edges as a stamp in the second slot where the first was expected. An error in the previous-level register or in the synchronizer depth shifts the stamped count by one. It can also produce a capture on an edge of the wrong polarity, and both show SYNC_STAGES cycles after the pin moves. The bench compares both slots and the event on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

   typedef enum logic [1:0] {
      CAP_OFF  = 2'd0,
      CAP_RISE = 2'd1,
      CAP_FALL = 2'd2,
      CAP_BOTH = 2'd3
   } cap_mode_e;

   localparam int CAP_SLOTS = 2;
   localparam int CAP_IDX_W = $clog2(CAP_SLOTS + 1);

endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ecp_edge_qual.sv
module ecp_edge_qual
   import edge_cap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      level_i,
   input  cap_mode_e mode_i,
   input  logic      pin_in_i,
   output logic      hit_o
);

   logic level_q;
   logic rise_w, fall_w, sel_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_i;
   end

   assign rise_w = level_i & ~level_q;
   assign fall_w = ~level_i & level_q;

   always_comb begin
      unique case (mode_i)
         CAP_RISE: sel_w = rise_w;
         CAP_FALL: sel_w = fall_w;
         CAP_BOTH: sel_w = rise_w | fall_w;
         default:  sel_w = 1'b0;
      endcase
   end

   assign hit_o = sel_w & pin_in_i;

endmodule

// File: rtl/ecp_slot_ctrl.sv
module ecp_slot_ctrl
   import edge_cap_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit_i,
   input  cap_mode_e            mode_i,
   input  logic                 clr_i,
   input  logic                 sel_i,
   output logic [CAP_IDX_W-1:0] slot_o,
   output logic [CAP_SLOTS-1:0] wr_en_o,
   output logic                 event_o
);

   cap_mode_e              mode_q;
   logic [CAP_IDX_W-1:0]   slot_q;
   logic                   rearm_w, take_w, evt_w;

   assign rearm_w = clr_i | ((mode_q == CAP_OFF) & (mode_i != CAP_OFF));
   assign take_w  = hit_i & ~rearm_w & (slot_q < CAP_IDX_W'(CAP_SLOTS));
   assign evt_w   = take_w & (slot_q == CAP_IDX_W'(sel_i));

   for (genvar i = 0; i < CAP_SLOTS; i++) begin : g_wr
      assign wr_en_o[i] = take_w & (slot_q == CAP_IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= CAP_OFF;
         slot_q  <= '0;
         event_o <= 1'b0;
      end else begin
         mode_q  <= mode_i;
         event_o <= evt_w;
         if (rearm_w)     slot_q <= '0;
         else if (take_w) slot_q <= slot_q + CAP_IDX_W'(1);
      end
   end

   assign slot_o = slot_q;

endmodule

// File: rtl/ecp_capture_regs.sv
module ecp_capture_regs
   import edge_cap_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [CAP_SLOTS-1:0]            wr_en_i,
   input  logic [CNT_W-1:0]                count_i,
   output logic [CAP_SLOTS-1:0][CNT_W-1:0] slot_val_o
);

   for (genvar i = 0; i < CAP_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          slot_val_o[i] <= '0;
         else if (wr_en_i[i]) slot_val_o[i] <= count_i;
      end
   end

endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
   import edge_cap_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_async_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [1:0]       cap_mode_i,
   input  logic             second_sel_i,
   input  logic             pin_is_input_i,
   input  logic             cap_clr_i,
   output logic [CNT_W-1:0] cap_first_o,
   output logic [CNT_W-1:0] cap_second_o,
   output logic             cap_event_o
);

   if (CNT_W < 1) begin : g_bad_width
      $error("edge_capture_pair: CNT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_capture_pair: SYNC_STAGES must be at least 2");
   end

   cap_mode_e                       mode_w;
   logic                            level_w;
   logic                            hit_w;
   logic [CAP_IDX_W-1:0]            slot_q;
   logic [CAP_SLOTS-1:0]            wr_en_w;
   logic [CAP_SLOTS-1:0][CNT_W-1:0] slot_val_w;

   assign mode_w = cap_mode_e'(cap_mode_i);

   ecp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_async_i),
      .q_sync  (level_w)
   );

   ecp_edge_qual u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (level_w),
      .mode_i   (mode_w),
      .pin_in_i (pin_is_input_i),
      .hit_o    (hit_w)
   );

   ecp_slot_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_w),
      .mode_i  (mode_w),
      .clr_i   (cap_clr_i),
      .sel_i   (second_sel_i),
      .slot_o  (slot_q),
      .wr_en_o (wr_en_w),
      .event_o (cap_event_o)
   );

   ecp_capture_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_w),
      .count_i    (count_i),
      .slot_val_o (slot_val_w)
   );

   assign cap_first_o  = slot_val_w[0];
   assign cap_second_o = slot_val_w[1];

endmodule

// File: rtl/edge_capture_pair_chk.sv
module edge_capture_pair_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cap_mode_i,
   input logic             second_sel_i,
   input logic             pin_is_input_i,
   input logic             cap_clr_i,
   input logic [CNT_W-1:0] cap_first_o,
   input logic [CNT_W-1:0] cap_second_o,
   input logic             cap_event_o,
   input logic [1:0]       slot
);

   // R8: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R8: assert (cap_first_o == '0 && cap_second_o == '0
                                        && !cap_event_o && slot == 2'd0)
            else $error("reset state not clean");
      end
   end

   assert_mode_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode_i == 2'd0) |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o))
      else $error("capture while mode is off");

   assert_dir_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_is_input_i |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o))
      else $error("capture while pin is an output");

   assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= 2'd2)
      else $error("slot index out of range");

   assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == 2'd2) |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o))
      else $error("slot written while full");

   assert_clear_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clr_i |=> (slot == 2'd0))
      else $error("clear did not rearm");

   assert_event_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_event_o |-> (slot == ($past(second_sel_i) ? 2'd2 : 2'd1)))
      else $error("event on wrong capture");

   assert_rearm_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clr_i |=> ($stable(cap_first_o) && $stable(cap_second_o) && !cap_event_o))
      else $error("capture in rearm cycle");

endmodule

bind edge_capture_pair edge_capture_pair_chk #(.CNT_W(CNT_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cap_mode_i     (cap_mode_i),
   .second_sel_i   (second_sel_i),
   .pin_is_input_i (pin_is_input_i),
   .cap_clr_i      (cap_clr_i),
   .cap_first_o    (cap_first_o),
   .cap_second_o   (cap_second_o),
   .cap_event_o    (cap_event_o),
   .slot           (slot_q)
);

// File: tb/edge_capture_pair_bench.sv
module edge_capture_pair_bench;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 32;
   localparam int STAGES     = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin = 1'b0;
   logic             dir = 1'b0;
   logic             sel = 1'b0;
   logic             clr = 1'b0;
   logic [1:0]       mode = 2'd0;
   logic [CNT_W-1:0] cyc = 32'hFFFF_FFF0;
   logic [CNT_W-1:0] cap1, cap2;
   logic             evt;

   int    compared = 0;
   int    mismatched = 0;
   string cur_req = "R8";
   bit    cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   edge_capture_pair #(.CNT_W(CNT_W), .SYNC_STAGES(STAGES)) u_edge_capture_pair (
      .clk            (clk),
      .rst_n          (rst_n),
      .pin_async_i    (pin),
      .count_i        (cyc),
      .cap_mode_i     (mode),
      .second_sel_i   (sel),
      .pin_is_input_i (dir),
      .cap_clr_i      (clr),
      .cap_first_o    (cap1),
      .cap_second_o   (cap2),
      .cap_event_o    (evt)
   );

   // behavioural reference model
   bit          syncq[$];
   bit          m_prev = 1'b0;
   logic [1:0]  m_mode_prev = 2'd0;
   int          m_idx = 0;
   logic [31:0] m_cap[2] = '{32'd0, 32'd0};
   bit          m_evt = 1'b0;

   initial for (int i = 0; i < STAGES; i++) syncq.push_back(1'b0);

   always @(posedge clk) begin
      bit lvl, q, rearm;
      if (!rst_n) begin
         syncq = {};
         for (int i = 0; i < STAGES; i++) syncq.push_back(1'b0);
         m_prev = 0; m_mode_prev = 0; m_idx = 0;
         m_cap[0] = 0; m_cap[1] = 0; m_evt = 0;
      end else begin
         lvl = syncq[STAGES-1];
         q = 0;
         if (dir) begin
            case (mode)
               2'd1: q = lvl && !m_prev;
               2'd2: q = !lvl && m_prev;
               2'd3: q = (lvl != m_prev);
               default: q = 0;
            endcase
         end
         rearm = clr || (m_mode_prev == 2'd0 && mode != 2'd0);
         m_evt = 0;
         if (rearm) m_idx = 0;
         else if (q && m_idx < 2) begin
            m_cap[m_idx] = cyc;
            if (m_idx == int'(sel)) m_evt = 1;
            m_idx++;
         end
         m_prev = lvl;
         m_mode_prev = mode;
         syncq.push_front(pin);
         void'(syncq.pop_back());
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(cur_req, cap1, m_cap[0], "first slot");
         chk(cur_req, cap2, m_cap[1], "second slot");
         chk(cur_req, {31'd0, evt}, {31'd0, m_evt}, "event");
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pin(bit v);
      pin = v;
      wait_n(4);
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      wait_n(1);
      clr = 1'b0;
      wait_n(1);
   endtask

   initial begin
      logic [31:0] c0, s1, s2;
      wait_n(3);
      // R8: reset state
      chk("R8", cap1, 32'd0, "reset first slot");
      chk("R8", cap2, 32'd0, "reset second slot");
      chk("R8", {31'd0, evt}, 32'd0, "reset event");
      rst_n = 1'b1;
      cmp_on = 1'b1;
      wait_n(2);

      // R3 / R7: rising mode, event on first capture
      cur_req = "R3";
      dir = 1; mode = 2'd1; sel = 0;
      wait_n(2);
      set_pin(1); set_pin(0); set_pin(1); set_pin(0);
      // R4: full, further edges ignored
      cur_req = "R4";
      s1 = cap1; s2 = cap2;
      set_pin(1); set_pin(0); set_pin(1); set_pin(0);
      chk("R4", cap1, s1, "full hold first");
      chk("R4", cap2, s2, "full hold second");

      // R5 + R9: clear rearms, latency of stamp
      cur_req = "R5";
      pulse_clr();
      wait_n(2);
      pin = 1'b1;
      c0 = cyc;
      wait_n(STAGES + 1);
      chk("R9", cap1, c0 + STAGES, "stamp latency");
      chk("R7", {31'd0, evt}, 32'd1, "event with first capture");
      wait_n(3);
      set_pin(0);

      // R7: event on second capture, falling mode
      cur_req = "R7";
      sel = 1; mode = 2'd2;
      pulse_clr();
      set_pin(1); set_pin(0); set_pin(1); set_pin(0);

      // R1: both edges, and none mode
      cur_req = "R1";
      mode = 2'd3; sel = 0;
      pulse_clr();
      set_pin(1); set_pin(0);
      mode = 2'd0;
      wait_n(2);
      pulse_clr();
      s1 = cap1;
      set_pin(1); set_pin(0);
      chk("R1", cap1, s1, "mode none ignores edges");

      // R6: none -> rising rearms
      cur_req = "R6";
      mode = 2'd1;
      wait_n(2);
      set_pin(1); set_pin(0); set_pin(1); set_pin(0);
      mode = 2'd2;            // nonzero -> nonzero: no rearm
      wait_n(2);
      s2 = cap2;
      set_pin(1); set_pin(0);
      chk("R6", cap2, s2, "no rearm between modes");
      mode = 2'd0; wait_n(2); mode = 2'd3; wait_n(2);
      set_pin(1);

      // R2: pin as output
      cur_req = "R2";
      pulse_clr();
      dir = 0;
      s1 = cap1; s2 = cap2;
      set_pin(0); set_pin(1); set_pin(0);
      chk("R2", cap1, s1, "output direction first");
      chk("R2", cap2, s2, "output direction second");
      dir = 1;

      // R10: clear colliding with edges every cycle
      cur_req = "R10";
      mode = 2'd3;
      for (int i = 0; i < 40; i++) begin
         pin = ~pin;
         clr = (i % 3 != 0);
         wait_n(1);
      end
      clr = 0;

      // mixed random traffic
      cur_req = "R3";
      for (int i = 0; i < 4000; i++) begin
         if ($urandom % 3 == 0) pin = ~pin;
         clr = ($urandom % 24 == 0);
         if ($urandom % 50 == 0) mode = 2'($urandom % 4);
         if ($urandom % 80 == 0) sel = ~sel;
         if ($urandom % 120 == 0) dir = ~dir;
         wait_n(1);
      end
      clr = 0;
      wait_n(4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule